// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block handles the relative-jump instruction format of a 16-bit processor. It looks at an instruction word, decides whether the word is a jump, checks the jump's condition against the four status flags (negative, zero, carry, overflow), and produces the address of the next instruction. That address is either the branch target or the sequential address. The unit only reads the flags and never changes them.

Two copies of the result are given. The first is purely combinational and follows the inputs within the same cycle. The second is registered: when the input strobe `in_valid` is high, the result is captured at the clock edge. It then appears on the `r_*` outputs in the next cycle, with `r_valid` high for exactly that one cycle. Between strobes the registered outputs hold their values.

A fetch stage supplies the instruction word and its own address. A flag unit supplies the status bits. Building the flags, fetching instructions and decoding the other instruction formats are all outside this block.

Top module: `branch_unit`

## Requirements
- R1: A word is a jump (`is_jump`=1) exactly when bits 15:13 equal 3'b001. For any other word, `taken` is 0.
- R2: For a jump, bits 12:10 select the condition, and `taken` follows this rule:
  - 3'b000: Z=0
  - 3'b001: Z=1
  - 3'b010: C=0
  - 3'b011: C=1
  - 3'b100: N=1
  - 3'b101: N==V
  - 3'b110: N!=V
  - 3'b111: always taken
- R3: When `taken`=1, `next_pc` equals `pc` + 2 + 2 × (sign-extended bits 9:0), computed modulo 2^16.
- R4: When `taken`=0, which includes every non-jump word, `next_pc` equals `pc` + 2.
- R5: Bit 0 of `next_pc` and of `r_next_pc` is always 0, including when `pc` is odd.
- R6: The 10-bit offset covers -512 to +511 words, and targets that cross the ends of the 16-bit address space wrap around.
- R7: A cycle with `in_valid`=1 makes `r_valid`=1 in the following cycle. In that cycle `r_is_jump`, `r_taken` and `r_next_pc` equal the combinational results of the strobed cycle. After a cycle with `in_valid`=0, `r_valid` is 0 and the other registered outputs are unchanged.
- R8: During reset, and until the first strobe, `r_valid`, `r_is_jump`, `r_taken` and `r_next_pc` are all 0.
- R9: Word 0x23FD at address 0xF82C with Z=0 is a taken not-equal jump to 0xF828. Word 0x2FE4 with C=1 is a taken carry-set jump of -28 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Strobe: capture the current result into the registered outputs |
| instr | input | 16 | Instruction word |
| pc | input | 16 | Address of the instruction word |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| is_jump | output | 1 | Word is a relative jump (combinational) |
| taken | output | 1 | Jump condition holds (combinational) |
| next_pc | output | 16 | Address of the next instruction (combinational) |
| r_valid | output | 1 | Registered result is fresh this cycle |
| r_is_jump | output | 1 | Registered copy of `is_jump` |
| r_taken | output | 1 | Registered copy of `taken` |
| r_next_pc | output | 16 | Registered copy of `next_pc` |

## Verification
The assertions check the following on every cycle:
- The timing of the registered stage: the one-cycle delay and the hold between strobes.
- That non-jump words are never taken.
- That an untaken result always falls through to the sequential address.
- That the always-taken code is taken.
- That bit 0 of every produced address is 0.

Some things only the bench's scenarios can show. These are the exact target arithmetic across the full offset range, address wrap, each of the eight flag conditions (the signed ones in particular), and the two worked instruction words.

// File: rtl/branch_pkg.sv
package branch_pkg;
  typedef enum logic [2:0] {
    CC_NOT_ZERO  = 3'b000,
    CC_ZERO      = 3'b001,
    CC_CARRY_CLR = 3'b010,
    CC_CARRY_SET = 3'b011,
    CC_NEGATIVE  = 3'b100,
    CC_SGN_GE    = 3'b101,
    CC_SGN_LT    = 3'b110,
    CC_ALWAYS    = 3'b111
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam logic [2:0] JUMP_FORMAT_TAG = 3'b001;
endpackage

// File: rtl/branch_rst_sync.sv
module branch_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/branch_decode.sv
module branch_decode
  import branch_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int COND_W  = 3,
  parameter int OFF_W   = 10
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               is_jump,
  output cond_e              cond,
  output logic [OFF_W-1:0]   offset
);
  localparam int TAG_W = INSTR_W - COND_W - OFF_W;

  assign is_jump = (instr[INSTR_W-1 -: TAG_W] == TAG_W'(JUMP_FORMAT_TAG));
  assign cond    = cond_e'(instr[OFF_W +: COND_W]);
  assign offset  = instr[OFF_W-1:0];
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import branch_pkg::*;
(
  input  logic   is_jump,
  input  cond_e  cond,
  input  flags_t flags,
  output logic   taken
);
  logic cond_true;

  always_comb begin
    unique case (cond)
      CC_NOT_ZERO:  cond_true = !flags.z;
      CC_ZERO:      cond_true = flags.z;
      CC_CARRY_CLR: cond_true = !flags.c;
      CC_CARRY_SET: cond_true = flags.c;
      CC_NEGATIVE:  cond_true = flags.n;
      CC_SGN_GE:    cond_true = (flags.n == flags.v);
      CC_SGN_LT:    cond_true = (flags.n != flags.v);
      default:      cond_true = 1'b1;
    endcase
  end

  assign taken = is_jump & cond_true;
endmodule

// File: rtl/branch_target.sv
module branch_target #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 10
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  offset,
  input  logic              taken,
  output logic [ADDR_W-1:0] next_pc
);
  localparam int EXT_W = ADDR_W - OFF_W - 1;

  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] disp;

  assign seq_pc  = {pc[ADDR_W-1:1], 1'b0} + ADDR_W'(2);
  assign disp    = {{EXT_W{offset[OFF_W-1]}}, offset, 1'b0};
  assign next_pc = taken ? (seq_pc + disp) : seq_pc;
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import branch_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int INSTR_W     = 16,
  parameter int COND_W      = 3,
  parameter int OFF_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0] pc,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  output logic              is_jump,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc,
  output logic              r_valid,
  output logic              r_is_jump,
  output logic              r_taken,
  output logic [ADDR_W-1:0] r_next_pc
);
  logic             rst_n_sync;
  cond_e            cond;
  logic [OFF_W-1:0] offset;
  flags_t           flags;

  assign flags = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

  branch_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  branch_decode #(.INSTR_W(INSTR_W), .COND_W(COND_W), .OFF_W(OFF_W)) u_dec (
    .instr(instr), .is_jump(is_jump), .cond(cond), .offset(offset)
  );

  branch_cond_eval u_cond (
    .is_jump(is_jump), .cond(cond), .flags(flags), .taken(taken)
  );

  branch_target #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
    .pc(pc), .offset(offset), .taken(taken), .next_pc(next_pc)
  );

  // Registered result stage: next-state logic, then flops with clock enable.
  logic              valid_d, jump_d, taken_d;
  logic [ADDR_W-1:0] pc_d;

  always_comb begin
    valid_d = in_valid;
    jump_d  = r_is_jump;
    taken_d = r_taken;
    pc_d    = r_next_pc;
    if (in_valid) begin
      jump_d  = is_jump;
      taken_d = taken;
      pc_d    = next_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      r_valid   <= 1'b0;
      r_is_jump <= 1'b0;
      r_taken   <= 1'b0;
      r_next_pc <= '0;
    end else begin
      r_valid   <= valid_d;
      r_is_jump <= jump_d;
      r_taken   <= taken_d;
      r_next_pc <= pc_d;
    end
  end
endmodule

module branch_unit_checker #(
  parameter int ADDR_W  = 16,
  parameter int INSTR_W = 16
) (
  input logic              clk,
  input logic              rst_n_sync,
  input logic              in_valid,
  input logic [INSTR_W-1:0] instr,
  input logic [ADDR_W-1:0] pc,
  input logic              is_jump,
  input logic              taken,
  input logic [ADDR_W-1:0] next_pc,
  input logic              r_valid,
  input logic              r_is_jump,
  input logic              r_taken,
  input logic [ADDR_W-1:0] r_next_pc
);
  p_nonjump_idle_r1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !is_jump |-> !taken);

  p_always_taken_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (is_jump && instr[12:10] == 3'b111) |-> taken);

  p_fallthrough_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !taken |-> next_pc == (({pc[ADDR_W-1:1], 1'b0}) + ADDR_W'(2)));

  p_even_comb_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    next_pc[0] == 1'b0);

  p_even_reg_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    r_next_pc[0] == 1'b0);

  p_strobe_capture_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    in_valid |=> (r_valid && r_next_pc == $past(next_pc)
                  && r_taken == $past(taken) && r_is_jump == $past(is_jump)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !in_valid |=> (!r_valid && $stable(r_next_pc) && $stable(r_taken)
                   && $stable(r_is_jump)));

  p_reg_taken_jump_r1: assert property (@(posedge clk) disable iff (!rst_n_sync)
    r_taken |-> r_is_jump);
endmodule

bind branch_unit branch_unit_checker #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_chk (
  .clk(clk), .rst_n_sync(rst_n_sync), .in_valid(in_valid), .instr(instr), .pc(pc),
  .is_jump(is_jump), .taken(taken), .next_pc(next_pc), .r_valid(r_valid),
  .r_is_jump(r_is_jump), .r_taken(r_taken), .r_next_pc(r_next_pc)
);

// File: tb/branch_unit_tb.sv
module branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] instr, pc;
  logic        flag_n, flag_z, flag_c, flag_v;
  logic        is_jump, taken, r_valid, r_is_jump, r_taken;
  logic [15:0] next_pc, r_next_pc;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  branch_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
    .is_jump(is_jump), .taken(taken), .next_pc(next_pc),
    .r_valid(r_valid), .r_is_jump(r_is_jump), .r_taken(r_taken), .r_next_pc(r_next_pc)
  );

  function automatic bit m_jump(input logic [15:0] w);
    return w[15:13] == 3'b001;
  endfunction

  function automatic bit m_taken(input logic [15:0] w, input bit n, z, c, v);
    bit t;
    if (!m_jump(w)) return 1'b0;
    case (w[12:10])
      3'd0: t = !z;
      3'd1: t = z;
      3'd2: t = !c;
      3'd3: t = c;
      3'd4: t = n;
      3'd5: t = (n == v);
      3'd6: t = (n != v);
      default: t = 1'b1;
    endcase
    return t;
  endfunction

  function automatic logic [15:0] m_next(input logic [15:0] w, input logic [15:0] a, input bit tk);
    int base, off;
    base = (int'(a) & 32'hFFFE) + 2;
    off  = w[9] ? int'(w[9:0]) - 1024 : int'(w[9:0]);
    if (tk) return 16'((base + 2 * off) & 32'hFFFE);
    return 16'(base & 32'hFFFE);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] w, input logic [15:0] a, input bit n, z, c, v, input bit vld);
    instr = w; pc = a; flag_n = n; flag_z = z; flag_c = c; flag_v = v; in_valid = vld;
  endtask

  // Check the combinational outputs for the present inputs.
  task automatic chk_comb(input string req);
    bit t;
    logic [15:0] np;
    t  = m_taken(instr, flag_n, flag_z, flag_c, flag_v);
    np = m_next(instr, pc, t);
    chk(is_jump == m_jump(instr), {req, " is_jump"}, 32'(is_jump), 32'(m_jump(instr)));
    chk(taken == t, {req, " taken"}, 32'(taken), 32'(t));
    chk(next_pc == np, {req, " next_pc"}, 32'(next_pc), 32'(np));
  endtask

  bit          e_valid, e_jump, e_taken;
  logic [15:0] e_pc;

  task automatic step(input string req, input logic [15:0] w, input logic [15:0] a,
                      input bit n, z, c, v, input bit vld);
    @(negedge clk);
    chk(r_valid == e_valid, "R7 r_valid", 32'(r_valid), 32'(e_valid));
    chk(r_is_jump == e_jump, "R7 r_is_jump", 32'(r_is_jump), 32'(e_jump));
    chk(r_taken == e_taken, "R7 r_taken", 32'(r_taken), 32'(e_taken));
    chk(r_next_pc == e_pc, "R7 r_next_pc", 32'(r_next_pc), 32'(e_pc));
    chk(r_next_pc[0] == 1'b0, "R5 r_next_pc bit0", 32'(r_next_pc[0]), 32'd0);
    drive(w, a, n, z, c, v, vld);
    #1;
    chk_comb(req);
    e_valid = vld;
    if (vld) begin
      e_jump  = m_jump(w);
      e_taken = m_taken(w, n, z, c, v);
      e_pc    = m_next(w, a, e_taken);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0B7A_5EED));
    rst_n = 1'b0;
    drive(16'h0, 16'h0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(r_valid == 1'b0, "R8 r_valid", 32'(r_valid), 0);
    chk(r_is_jump == 1'b0, "R8 r_is_jump", 32'(r_is_jump), 0);
    chk(r_taken == 1'b0, "R8 r_taken", 32'(r_taken), 0);
    chk(r_next_pc == 16'h0, "R8 r_next_pc", 32'(r_next_pc), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(r_valid == 1'b0 && r_next_pc == 16'h0, "R8 after release", 32'(r_next_pc), 0);
    e_valid = 0; e_jump = 0; e_taken = 0; e_pc = 16'h0;

    // R9 worked words
    step("R9 ne taken", 16'h23FD, 16'hF82C, 0, 0, 0, 0, 1);
    chk(next_pc == 16'hF828, "R9 target 0xF828", 32'(next_pc), 32'hF828);
    step("R9 ne not taken", 16'h23FD, 16'hF82C, 0, 1, 0, 0, 1);
    step("R9 carry set", 16'h2FE4, 16'h1000, 0, 0, 1, 0, 1);
    chk(next_pc == 16'h0FCA, "R9 -28 words", 32'(next_pc), 32'h0FCA);
    step("R9 carry clear", 16'h2FE4, 16'h1000, 0, 0, 0, 0, 1);
    // R1 / R4 non-jump words
    step("R1 R4 non-jump", 16'h4504, 16'h2000, 1, 1, 1, 1, 1);
    step("R1 R4 tag 000", 16'h1C05, 16'h2000, 1, 1, 1, 1, 0);
    step("R1 R4 tag 011", 16'h7C05, 16'h2000, 1, 1, 1, 1, 1);
    // R6 offset extremes and wrap
    step("R6 min offset", 16'h3E00, 16'h0400, 0, 0, 0, 0, 1);
    chk(next_pc == 16'h0002, "R6 -512 words", 32'(next_pc), 32'h0002);
    step("R6 max offset wrap", 16'h3DFF, 16'hFFF0, 0, 0, 0, 0, 1);
    chk(next_pc == 16'h03F0, "R6 +511 words wrap", 32'(next_pc), 32'h03F0);
    step("R6 wrap below zero", 16'h3E00, 16'h0010, 0, 0, 0, 0, 1);
    // R5 odd address
    step("R5 odd pc taken", 16'h3C05, 16'h1235, 0, 0, 0, 0, 1);
    chk(next_pc == 16'h1240, "R5 odd pc", 32'(next_pc), 32'h1240);
    step("R5 odd pc not taken", 16'h2005, 16'hFFFF, 0, 1, 0, 0, 1);
    // R2 every condition, every flag combination
    for (int cc = 0; cc < 8; cc++) begin
      for (int f = 0; f < 16; f++) begin
        step("R2 R3 cond table", {3'b001, 3'(cc), 10'h013}, 16'h8000,
             f[3], f[2], f[1], f[0], f[0] ^ f[2]);
      end
    end
    // R7 hold across several idle cycles
    step("R7 strobe", 16'h3C10, 16'h4000, 0, 0, 0, 0, 1);
    step("R7 idle", 16'h2001, 16'h5000, 0, 0, 0, 0, 0);
    step("R7 idle", 16'h4504, 16'h6000, 0, 0, 0, 0, 0);
    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if ($urandom % 4 != 0) w[15:13] = 3'b001;
      step("R1 R2 R3 R4 R7 random", w, 16'($urandom), bit'($urandom), bit'($urandom),
           bit'($urandom), bit'($urandom), bit'($urandom));
    end
    step("R7 final", 16'h4504, 16'h0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule